// File: doc/BRIEF.md
# Nested Priority Event Controller

This block is the core-side arbiter for nine general-purpose interrupt levels, numbered 7 to 15, with level 7 the most urgent. Each level has one input from the system side. A rising edge on an input is caught by a two-flop edge detector and held in a latch register. A mask register and a global enable decide which latched levels may ask for service. The controller raises a service request only when the most urgent eligible level outranks every level that is already in service. It reports that level as a 4-bit identifier.

The core accepts a request by pulsing an acknowledge input. That sets the level's bit in the pending register and clears its latch bit in the same edge. Several levels can be in service at once when they are nested. A return strobe retires the most urgent of them, and service falls back to the level that was interrupted. Once a level is pending, a fresh rising edge on its input latches again, so a second event waits behind the one in service.

Software sees three 32-bit registers through a flat select/data port. Level k sits at bit k and every other bit reads as zero. The latch register is write-one-to-clear, which cancels latched events. The mask register is read/write. The pending register is read-only. The reset input is asynchronous and active-low, and is expected to be released in step with the clock.

Top module: `prio_evt_ctrl`

## Requirements
- R1: Level k (7..15) is driven by irq_in[k-7] and occupies bit k of the latch, mask and pending registers. Lower level numbers win, and svc_id carries the level number k.
- R2: A rising edge on irq_in sets the level's latch bit at the second clock edge after the input rises. An input that stays high sets nothing further.
- R3: When svc_req and svc_ack are both high at a clock edge, the pending bit of level svc_id is set and its latch bit is cleared at that edge.
- R4: A masked level (mask bit 0) still latches but never raises svc_req. After reset every mask bit is 0.
- R5: A write with reg_sel 0 (latch) clears each latch bit whose wr_data bit is 1 and leaves the others.
- R6: The pending register (reg_sel 2) ignores writes and only gains a bit through an accepted request.
- R7: A rising edge that reaches the latch in the same edge that accepts that level leaves the latch bit set, queued behind the level now in service.
- R8: glb_on enables requests and glb_off disables them. If both are high, glb_off wins. Requests are disabled after reset.
- R9: svc_req is high only when the most urgent latched, unmasked and enabled level is more urgent than the most urgent pending level. With nothing pending, any eligible level qualifies.
- R10: ret_evt clears the most urgent set pending bit, and only that bit.
- R11: rd_data is 32 bits. Bits outside 7..15 always read zero, and reg_sel 3 reads all zero. All registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 9 | Level inputs, bit i drives level i+7 |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 latch, 1 mask, 2 pending, 3 none |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for reg_sel (combinational) |
| glb_on | input | 1 | Enable requests as a group |
| glb_off | input | 1 | Disable requests as a group |
| svc_ack | input | 1 | Core accepts the current request |
| ret_evt | input | 1 | Return from the innermost event in service |
| svc_req | output | 1 | Service request |
| svc_id | output | 4 | Level number of the requested event |

## Verification
Two things can land on one level in the same edge: the acceptance that clears its latch bit, and a new rising edge that sets it. The bench provokes this by pulsing a level's input low and high again, so that the second edge's detection cycle lines up with the cycle in which svc_ack is held. After that edge it expects the pending bit set, the latch bit still set, and no request, because the queued event does not outrank the level now in service. A second collision, glb_on and glb_off raised together, is judged by the absence of a request.

// File: rtl/pec_pkg.sv
package pec_pkg;
  localparam int PEC_LEVELS = 9;
  localparam int PEC_BASE   = 7;
  localparam int PEC_REG_W  = 32;
  localparam int PEC_ID_W   = 4;

  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_PEND  = 2'd2,
    SEL_NONE  = 2'd3
  } pec_sel_e;
endpackage

// File: rtl/pec_edge.sv
// Two-flop rising edge detector, one lane per level.
module pec_edge #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_lane
    logic smp_q, old_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q <= 1'b0;
        old_q <= 1'b0;
      end else begin
        smp_q <= din[g];
        old_q <= smp_q;
      end
    end
    assign rise[g] = smp_q & ~old_q;
  end
endmodule

// File: rtl/pec_first.sv
// Finds the lowest set index (most urgent level); idx = N when none.
module pec_first #(
  parameter int N  = 9,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = IW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    found = |vec;
  end
endmodule

// File: rtl/prio_evt_ctrl.sv
module prio_evt_ctrl
  import pec_pkg::*;
#(
  parameter int N     = PEC_LEVELS,
  parameter int BASE  = PEC_BASE,
  parameter int REG_W = PEC_REG_W,
  parameter int ID_W  = PEC_ID_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_in,
  input  logic             wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             glb_on,
  input  logic             glb_off,
  input  logic             svc_ack,
  input  logic             ret_evt,
  output logic             svc_req,
  output logic [ID_W-1:0]  svc_id
);
  localparam int IW = $clog2(N + 1);
  localparam logic [N-1:0] ONE = N'(1);

  logic [N-1:0] lat_q, lat_d, mask_q, mask_d, pnd_q, pnd_d;
  logic         glb_q, glb_d;
  logic [N-1:0] rise, cand, acc_oh, ret_oh, wr_lvl, sw_clr;
  logic         cand_found, pnd_found, mask_en, glb_en;
  logic [IW-1:0] cand_idx, pnd_idx;

  pec_edge #(.N(N)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(irq_in), .rise(rise)
  );

  assign cand = lat_q & mask_q & {N{glb_q}};

  pec_first #(.N(N), .IW(IW)) u_cand (
    .vec(cand), .found(cand_found), .idx(cand_idx)
  );
  pec_first #(.N(N), .IW(IW)) u_pend (
    .vec(pnd_q), .found(pnd_found), .idx(pnd_idx)
  );

  // Request and acknowledge
  always_comb begin
    svc_req = cand_found && (cand_idx < pnd_idx);
    svc_id  = ID_W'(cand_idx) + ID_W'(BASE);
    acc_oh  = (svc_req && svc_ack) ? (ONE << cand_idx) : '0;
    ret_oh  = (ret_evt && pnd_found) ? (ONE << pnd_idx) : '0;
  end

  // Next-state logic
  always_comb begin
    wr_lvl  = wr_data[BASE +: N];
    sw_clr  = (wr_en && reg_sel == SEL_LATCH) ? wr_lvl : '0;
    mask_en = wr_en && (reg_sel == SEL_MASK);
    mask_d  = wr_lvl;
    lat_d   = (lat_q & ~acc_oh & ~sw_clr) | rise;
    pnd_d   = (pnd_q & ~ret_oh) | acc_oh;
    glb_en  = glb_on | glb_off;
    glb_d   = ~glb_off;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      pnd_q  <= '0;
      mask_q <= '0;
      glb_q  <= 1'b0;
    end else begin
      lat_q <= lat_d;
      pnd_q <= pnd_d;
      if (mask_en) mask_q <= mask_d;
      if (glb_en)  glb_q  <= glb_d;
    end
  end

  // Register read
  always_comb begin
    unique case (reg_sel)
      SEL_LATCH: rd_data = REG_W'(lat_q)  << BASE;
      SEL_MASK:  rd_data = REG_W'(mask_q) << BASE;
      SEL_PEND:  rd_data = REG_W'(pnd_q)  << BASE;
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pec_chk.sv
module pec_chk #(
  parameter int N    = 9,
  parameter int BASE = 7,
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            svc_req,
  input logic [ID_W-1:0] svc_id,
  input logic            svc_ack,
  input logic            ret_evt,
  input logic            glb_q,
  input logic [N-1:0]    lat_q,
  input logic [N-1:0]    mask_q,
  input logic [N-1:0]    pnd_q
);
  logic [N-1:0] upto_id;
  always_comb begin
    for (int i = 0; i < N; i++) upto_id[i] = (i + BASE) <= int'(svc_id);
  end

  // R4
  req_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> mask_q[int'(svc_id) - BASE] && lat_q[int'(svc_id) - BASE]);

  // R3
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && svc_ack) |=> pnd_q[int'($past(svc_id)) - BASE]);

  // R8
  glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_q |-> !svc_req);

  // R9
  outranks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> (pnd_q & upto_id) == '0);

  // R6
  pend_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(svc_req && svc_ack) |=> (pnd_q & ~$past(pnd_q)) == '0);

  // R10
  ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_evt && !(svc_req && svc_ack) && pnd_q != '0)
      |=> $countones(pnd_q) == $countones($past(pnd_q)) - 1);
endmodule

bind prio_evt_ctrl pec_chk #(.N(N), .BASE(BASE), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .svc_req(svc_req), .svc_id(svc_id),
  .svc_ack(svc_ack), .ret_evt(ret_evt), .glb_q(glb_q), .lat_q(lat_q),
  .mask_q(mask_q), .pnd_q(pnd_q)
);

// File: tb/prio_evt_ctrl_bench.sv
module prio_evt_ctrl_bench;
  localparam int PERIOD = 10;

  logic        clk, rst_n;
  logic [8:0]  irq_in;
  logic        wr_en, glb_on, glb_off, svc_ack, ret_evt;
  logic [1:0]  reg_sel;
  logic [31:0] wr_data, rd_data;
  logic        svc_req;
  logic [3:0]  svc_id;
  int checks, errors;

  prio_evt_ctrl u_prio_evt_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
    .glb_on(glb_on), .glb_off(glb_off), .svc_ack(svc_ack),
    .ret_evt(ret_evt), .svc_req(svc_req), .svc_id(svc_id)
  );

  initial begin
    clk = 1'b0;
    forever #(PERIOD / 2) clk = ~clk;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(logic [1:0] sel);
    reg_sel = sel;
    return 32'(0);
  endfunction

  task automatic rdchk(string tag, logic [1:0] sel, logic [31:0] exp);
    reg_sel = sel;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ack();
    svc_ack = 1'b1;
    tick();
    svc_ack = 1'b0;
  endtask

  task automatic ret();
    ret_evt = 1'b1;
    tick();
    ret_evt = 1'b0;
  endtask

  task automatic t_reset();
    rdchk("R11 latch after reset", 2'd0, 32'h0);
    rdchk("R4 mask after reset", 2'd1, 32'h0);
    rdchk("R11 pending after reset", 2'd2, 32'h0);
    chk("R8 no request after reset", {31'b0, svc_req}, 32'h0);
  endtask

  task automatic t_latch_mask();
    irq_in[3] = 1'b1;                      // level 10
    tick();
    rdchk("R2 not latched after one edge", 2'd0, 32'h0);
    tick();
    rdchk("R2 latched after two edges", 2'd0, 32'h0000_0400);
    glb_on = 1'b1; tick(); glb_on = 1'b0;
    chk("R4 masked level gives no request", {31'b0, svc_req}, 32'h0);
    wr(2'd1, 32'h0000_0400);
    chk("R9 request raised", {31'b0, svc_req}, 32'h1);
    chk("R1 id equals level", {28'b0, svc_id}, 32'd10);
    glb_off = 1'b1; tick(); glb_off = 1'b0;
    chk("R8 disabled blocks request", {31'b0, svc_req}, 32'h0);
    glb_on = 1'b1; glb_off = 1'b1; tick(); glb_on = 1'b0; glb_off = 1'b0;
    chk("R8 disable wins over enable", {31'b0, svc_req}, 32'h0);
    glb_on = 1'b1; tick(); glb_on = 1'b0;
    chk("R8 enabled again", {31'b0, svc_req}, 32'h1);
  endtask

  task automatic t_regs();
    wr(2'd0, 32'h0000_0400);
    rdchk("R5 write-one clears latch", 2'd0, 32'h0);
    chk("R5 cancelled gives no request", {31'b0, svc_req}, 32'h0);
    tick(); tick();
    rdchk("R2 steady high does not relatch", 2'd0, 32'h0);
    wr(2'd2, 32'hFFFF_FFFF);
    rdchk("R6 pending ignores writes", 2'd2, 32'h0);
    wr(2'd1, 32'hFFFF_FFFF);
    rdchk("R11 unmapped bits read zero", 2'd1, 32'h0000_FF80);
    rdchk("R11 select 3 reads zero", 2'd3, 32'h0);
  endtask

  task automatic t_nesting();
    irq_in[5] = 1'b1; irq_in[1] = 1'b1;    // levels 12 and 8
    tick(); tick(); tick();
    chk("R1 level 8 wins over 12", {28'b0, svc_id}, 32'd8);
    ack();
    rdchk("R3 pending set on accept", 2'd2, 32'h0000_0100);
    rdchk("R3 latch cleared on accept", 2'd0, 32'h0000_1000);
    chk("R9 lower level cannot preempt", {31'b0, svc_req}, 32'h0);
    irq_in[0] = 1'b1;                      // level 7
    tick(); tick();
    chk("R9 higher level preempts", {31'b0, svc_req}, 32'h1);
    chk("R1 id for level 7", {28'b0, svc_id}, 32'd7);
    ack();
    rdchk("R3 nested pending", 2'd2, 32'h0000_0180);
    ret();
    rdchk("R10 return pops innermost", 2'd2, 32'h0000_0100);
    chk("R9 still blocked by level 8", {31'b0, svc_req}, 32'h0);
    ret();
    rdchk("R10 second return empties", 2'd2, 32'h0);
    chk("R9 level 12 now requested", {28'b0, svc_id}, 32'd12);
    chk("R9 request up after return", {31'b0, svc_req}, 32'h1);
  endtask

  task automatic t_requeue();
    irq_in[2] = 1'b1;                      // level 9
    tick(); tick();
    chk("R1 level 9 requested", {28'b0, svc_id}, 32'd9);
    irq_in[2] = 1'b0;
    tick();
    irq_in[2] = 1'b1;
    tick();
    ack();                                 // accept and new edge together
    rdchk("R7 pending set", 2'd2, 32'h0000_0200);
    rdchk("R7 new edge stays latched", 2'd0, 32'h0000_1200);
    chk("R9 queued same level waits", {31'b0, svc_req}, 32'h0);
    ret();
    chk("R10 queued level requested", {28'b0, svc_id}, 32'd9);
    wr(2'd0, 32'hFFFF_FFFF);
    rdchk("R5 clear all latches", 2'd0, 32'h0);
    chk("R5 no request left", {31'b0, svc_req}, 32'h0);
  endtask

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; irq_in = '0; wr_en = 1'b0; reg_sel = 2'd0; wr_data = '0;
    glb_on = 1'b0; glb_off = 1'b0; svc_ack = 1'b0; ret_evt = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_latch_mask();
    t_regs();
    t_nesting();
    t_requeue();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule